// File: doc/BRIEF.md
# Low-Speed USB Serial Receiver

This block watches a low-speed USB differential pair with a system clock that runs at a fixed multiple of the bit rate. It hunts for a J-to-K transition, and when a second K follows one bit time later it takes that as the end of the sync field and locks its sampling phase there. From then on it samples once per bit at a fixed offset. It turns the line levels back into bits through NRZI decoding, drops the stuffed zero that follows each run of six ones, and assembles bytes least significant bit first.

Each completed byte appears as a one-cycle strobe with its data, meant to be written into a downstream buffer whose capacity the block enforces. A single-ended zero on the line ends the packet, and the block then gives a one-cycle done pulse with the count of whole bytes. An SE0 at the first bit position of a byte is not taken as the end, because a hub may add a dribble bit there. The block does not look at what the packet holds.

Top module: `usbls_rx`

## Requirements
- R1: After reset, byteValid, pktDone and overflow are low and pktCount is zero.
- R2: The line is read as the pair {dPlus, dMinus}: J is 01 (idle), K is 10, SE0 is 00. The receiver locks only when a J-to-K transition is followed one bit time later by a K sample; the bit time after that second K is the first data bit.
- R3: Data bits are NRZI-decoded from the dMinus level: 1 when it equals the level of the previous bit, 0 when it differs. The reference level at lock is K (dMinus low).
- R4: Bits are packed least significant bit first; after every eighth data bit byteValid is high for exactly one cycle with the byte on byteData.
- R5: A run counter of decoded ones starts at 1 at lock (the final sync bit), is cleared by each decoded 0, and when it reaches 6 the next bit is dropped as stuffing and the counter is cleared.
- R6: An SE0 sample at any data bit position other than the first bit of a byte ends the packet: pktDone is high for one cycle and pktCount equals the number of complete bytes; a partial byte is discarded.
- R7: An SE0 sample at the first bit position of a byte does not end the packet; it is decoded as a K level (dMinus low).
- R8: The buffer holds BUF_BYTES bytes (default 4). When one more byte completes, overflow goes high, that byte gets no byteValid, the packet gives no pktDone, and the rest of the packet up to its SE0 is ignored. overflow stays high until the next lock.
- R9: A K that is followed by a J one bit later produces no lock and no output, and the search resumes at the next J-to-K transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, BIT_CLKS cycles per bit |
| rstN | input | 1 | Active-low asynchronous reset |
| dPlus | input | 1 | D+ line level |
| dMinus | input | 1 | D- line level |
| byteValid | output | 1 | One-cycle strobe for a completed byte |
| byteData | output | 8 | Byte received, valid with byteValid |
| pktDone | output | 1 | One-cycle pulse at packet end |
| pktCount | output | CNT_W | Number of complete bytes, valid with pktDone |
| overflow | output | 1 | Packet was longer than BUF_BYTES; held until next lock |

## Verification
The receiver is fed packets of one to four bytes whose values are chosen to tell the decoding paths apart: alternating bits, bytes of all zeros, and runs of ones long enough to cross byte borders and force stuffed bits. A run of all-ones bytes shows that the run counter carries across bytes and that it counts the last sync bit. A packet cut short by an SE0 in the middle of a byte shows partial bytes being dropped. A single SE0 bit at a byte's first position shows the dribble rule, since the byte that follows must carry a 1 or 0 there according to the previous level. A lone K pulse, an overlong packet, and a clean packet after it show that a false sync gives nothing, that the buffer limit is enforced, and that the overflow flag clears.

// File: rtl/usbls_pkg.sv
package usbls_pkg;

  // Line level as {D+, D-}
  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10,
    LINE_SE1 = 2'b11
  } lineState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic lock;      // sync end found, clear packet state
    logic takeBit;   // shift the decoded bit into the byte
    logic dropBit;   // stuffed bit, only refresh the NRZI reference
    logic byteDone;  // eighth bit taken, publish the byte
    logic endPkt;    // SE0 seen, publish the count
    logic abortPkt;  // buffer full, flag overflow
  } rxStrobes_t;

  localparam int BYTE_BITS = 8;

endpackage

// File: rtl/usbls_rx_datapath.sv
module usbls_rx_datapath
  import usbls_pkg::*;
#(
  parameter int BUF_BYTES = 4,
  localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dPlus,
  input  logic             dMinus,
  input  rxStrobes_t       strobes,
  output lineState_t       lineNow,
  output logic             edgeJK,
  output logic             decodedOne,
  output logic             bufFull,
  output logic             byteValid,
  output logic [7:0]       byteData,
  output logic             pktDone,
  output logic [CNT_W-1:0] pktCount,
  output logic             overflow
);

  logic [1:0] metaPair;
  logic [1:0] linePair;
  logic [1:0] prevPair;
  logic       refLevel;
  logic [7:0] shiftReg;
  logic [CNT_W-1:0] byteCount;
  logic [7:0] nextShift;

  // Two-stage synchronizer; idle J at reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaPair <= LINE_J;
      linePair <= LINE_J;
      prevPair <= LINE_J;
    end else begin
      metaPair <= {dPlus, dMinus};
      linePair <= metaPair;
      prevPair <= linePair;
    end
  end

  assign lineNow    = lineState_t'(linePair);
  assign edgeJK     = (prevPair == LINE_J) && (linePair == LINE_K);
  // Only D- takes part in decoding, so SE0 reads as a K level
  assign decodedOne = (linePair[0] == refLevel);
  assign bufFull    = (byteCount == CNT_W'(BUF_BYTES));
  assign nextShift  = {decodedOne, shiftReg[7:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refLevel  <= 1'b0;
      shiftReg  <= '0;
      byteCount <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
      pktDone   <= 1'b0;
      pktCount  <= '0;
      overflow  <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      pktDone   <= 1'b0;
      if (strobes.lock) begin
        refLevel  <= 1'b0;
        shiftReg  <= '0;
        byteCount <= '0;
        overflow  <= 1'b0;
      end
      if (strobes.takeBit || strobes.dropBit) begin
        refLevel <= linePair[0];
      end
      if (strobes.takeBit) begin
        shiftReg <= nextShift;
      end
      if (strobes.byteDone) begin
        byteValid <= 1'b1;
        byteData  <= nextShift;
        byteCount <= byteCount + 1'b1;
      end
      if (strobes.endPkt) begin
        pktDone  <= 1'b1;
        pktCount <= byteCount;
      end
      if (strobes.abortPkt) begin
        overflow <= 1'b1;
      end
    end
  end

  // Bytes come at least a byte time apart, so the strobe is one cycle wide
  assert_byte_pulse_R4 : assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  assert_done_pulse_R6 : assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone);

  assert_count_bound_R6 : assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> (pktCount <= CNT_W'(BUF_BYTES)));

  assert_no_done_after_overflow_R8 : assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !pktDone);

endmodule

// File: rtl/usbls_rx_ctrl.sv
module usbls_rx_ctrl
  import usbls_pkg::*;
#(
  parameter int BIT_CLKS  = 10,
  parameter int STUFF_RUN = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  lineState_t lineNow,
  input  logic       edgeJK,
  input  logic       decodedOne,
  input  logic       bufFull,
  output rxStrobes_t strobes
);

  localparam int HALF_BIT = BIT_CLKS / 2;
  localparam int SYNC_AT  = BIT_CLKS + HALF_BIT - 1;
  localparam int PH_W     = $clog2(SYNC_AT + 1);
  localparam int RUN_W    = $clog2(STUFF_RUN + 1);
  localparam int IDX_W    = $clog2(BYTE_BITS);

  typedef enum logic [1:0] {ST_HUNT, ST_SYNC, ST_DATA, ST_DRAIN} rxState_t;

  rxState_t         st, stNext;
  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] bitIdx;
  logic [RUN_W-1:0] onesRun;
  logic             sampleNow;

  assign sampleNow = (phase == PH_W'(BIT_CLKS - 1));

  always_comb begin
    strobes = '0;
    stNext  = st;
    unique case (st)
      ST_HUNT: begin
        if (edgeJK) stNext = ST_SYNC;
      end
      ST_SYNC: begin
        if (phase == PH_W'(SYNC_AT)) begin
          if (lineNow == LINE_K) begin
            strobes.lock = 1'b1;
            stNext = ST_DATA;
          end else begin
            stNext = ST_HUNT;
          end
        end
      end
      ST_DATA: begin
        if (sampleNow) begin
          if ((lineNow == LINE_SE0) && (bitIdx != '0)) begin
            strobes.endPkt = 1'b1;
            stNext = ST_HUNT;
          end else if (onesRun == RUN_W'(STUFF_RUN)) begin
            strobes.dropBit = 1'b1;
          end else begin
            strobes.takeBit = 1'b1;
            if (bitIdx == IDX_W'(BYTE_BITS - 1)) begin
              if (bufFull) begin
                strobes.abortPkt = 1'b1;
                stNext = ST_DRAIN;
              end else begin
                strobes.byteDone = 1'b1;
              end
            end
          end
        end
      end
      ST_DRAIN: begin
        if (lineNow == LINE_SE0) stNext = ST_HUNT;
      end
      default: stNext = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_HUNT;
      phase   <= '0;
      bitIdx  <= '0;
      onesRun <= '0;
    end else begin
      st <= stNext;
      if (stNext != st || st == ST_HUNT || st == ST_DRAIN || (st == ST_DATA && sampleNow)) begin
        phase <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
      if (strobes.lock) begin
        bitIdx  <= '0;
        onesRun <= RUN_W'(1);
      end else if (strobes.dropBit) begin
        onesRun <= '0;
      end else if (strobes.takeBit) begin
        bitIdx  <= bitIdx + 1'b1;
        onesRun <= decodedOne ? onesRun + 1'b1 : '0;
      end
    end
  end

  // At most one bit action per sample
  assert_one_action_R5 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.lock, strobes.takeBit, strobes.dropBit, strobes.endPkt}));

  // A stuffed bit never moves the byte position
  assert_drop_keeps_index_R5 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.dropBit |=> $stable(bitIdx));

  // Lock only follows the sync sampling state
  assert_lock_after_edge_R9 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.lock |-> (st == ST_SYNC) && (phase == PH_W'(SYNC_AT)));

endmodule

// File: rtl/usbls_rx.sv
module usbls_rx
  import usbls_pkg::*;
#(
  parameter int BIT_CLKS  = 10,
  parameter int STUFF_RUN = 6,
  parameter int BUF_BYTES = 4,
  localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dPlus,
  input  logic             dMinus,
  output logic             byteValid,
  output logic [7:0]       byteData,
  output logic             pktDone,
  output logic [CNT_W-1:0] pktCount,
  output logic             overflow
);

  rxStrobes_t strobes;
  lineState_t lineNow;
  logic       edgeJK;
  logic       decodedOne;
  logic       bufFull;

  usbls_rx_ctrl #(
    .BIT_CLKS (BIT_CLKS),
    .STUFF_RUN(STUFF_RUN)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineNow   (lineNow),
    .edgeJK    (edgeJK),
    .decodedOne(decodedOne),
    .bufFull   (bufFull),
    .strobes   (strobes)
  );

  usbls_rx_datapath #(
    .BUF_BYTES(BUF_BYTES)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .dPlus     (dPlus),
    .dMinus    (dMinus),
    .strobes   (strobes),
    .lineNow   (lineNow),
    .edgeJK    (edgeJK),
    .decodedOne(decodedOne),
    .bufFull   (bufFull),
    .byteValid (byteValid),
    .byteData  (byteData),
    .pktDone   (pktDone),
    .pktCount  (pktCount),
    .overflow  (overflow)
  );

endmodule

// File: tb/test_usbls_rx.sv
module test_usbls_rx;

  localparam int BIT = 10;
  localparam int BUF = 4;

  typedef struct packed {
    logic [2:0]  nBytes;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{3'd1, 32'h0000_00A5},
    '{3'd2, 32'h0000_FF00},
    '{3'd3, 32'h007E_3F01},
    '{3'd4, 32'hFFFF_FFFF},
    '{3'd2, 32'h0000_C080}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dPlus = 1'b0;
  logic       dMinus = 1'b1;
  logic       byteValid;
  logic [7:0] byteData;
  logic       pktDone;
  logic [2:0] pktCount;
  logic       overflow;

  int checks = 0;
  int errors = 0;
  logic [7:0] capData [8];
  int capN = 0;
  int doneSeen = 0;
  int doneCount = 0;
  logic curDm = 1'b1;
  int ones = 0;

  always #4 clk = ~clk;

  usbls_rx #(.BIT_CLKS(BIT), .BUF_BYTES(BUF)) i_usbls_rx (
    .clk(clk), .rstN(rstN), .dPlus(dPlus), .dMinus(dMinus),
    .byteValid(byteValid), .byteData(byteData), .pktDone(pktDone),
    .pktCount(pktCount), .overflow(overflow)
  );

  always @(negedge clk) begin
    if (byteValid) begin
      if (capN < 8) capData[capN] = byteData;
      capN = capN + 1;
    end
    if (pktDone) begin
      doneSeen = doneSeen + 1;
      doneCount = int'(pktCount);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearCap();
    capN = 0; doneSeen = 0; doneCount = 0;
  endtask

  task automatic driveLine(input logic p, input logic m);
    dPlus = p; dMinus = m;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic driveLevel();
    driveLine(!curDm, curDm);
  endtask

  task automatic sendIdle(input int n);
    curDm = 1'b1;
    for (int i = 0; i < n; i++) driveLevel();
  endtask

  // K J K J K J K K, then reference level is K and the run count is 1
  task automatic sendSync();
    for (int i = 0; i < 8; i++) begin
      curDm = (i % 2 == 1) && (i < 6);
      driveLevel();
    end
    curDm = 1'b0;
    ones = 1;
  endtask

  task automatic noteBit(input logic b);
    if (b) ones = ones + 1; else ones = 0;
    if (ones == 6) begin
      curDm = !curDm;
      driveLevel();
      ones = 0;
    end
  endtask

  task automatic sendBit(input logic b);
    if (!b) curDm = !curDm;
    driveLevel();
    noteBit(b);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  task automatic sendEop();
    driveLine(1'b0, 1'b0);
    driveLine(1'b0, 1'b0);
    sendIdle(3);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!byteValid && !pktDone && !overflow && pktCount == 0, "R1 reset outputs",
          {byteValid, pktDone, overflow, pktCount}, 0);

    // Table of packets: R2 R3 R4 R5 R6
    foreach (VECS[v]) begin
      clearCap();
      sendIdle(4);
      sendSync();
      for (int b = 0; b < int'(VECS[v].nBytes); b++) sendByte(VECS[v].data[8*b +: 8]);
      sendEop();
      check(capN == int'(VECS[v].nBytes), "R4 byte strobes", capN, int'(VECS[v].nBytes));
      for (int b = 0; b < int'(VECS[v].nBytes); b++)
        check(capData[b] == VECS[v].data[8*b +: 8], "R3 R5 byte value",
              int'(capData[b]), int'(VECS[v].data[8*b +: 8]));
      check(doneSeen == 1 && doneCount == int'(VECS[v].nBytes), "R6 done count",
            doneCount, int'(VECS[v].nBytes));
      check(!overflow, "R8 no overflow", int'(overflow), 0);
    end

    // R6 partial byte discarded: SE0 at bit index 3
    clearCap();
    sendIdle(4);
    sendSync();
    sendByte(8'h5A);
    sendByte(8'h13);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    sendEop();
    check(capN == 2, "R6 partial bytes strobed", capN, 2);
    check(doneSeen == 1 && doneCount == 2, "R6 partial discarded", doneCount, 2);

    // R7 dribble SE0 at first bit decodes as K and the packet goes on
    begin
      logic b0;
      logic [7:0] tail;
      tail = 8'h4C;
      clearCap();
      sendIdle(4);
      sendSync();
      sendByte(8'h21);
      b0 = (curDm == 1'b0);
      driveLine(1'b0, 1'b0);
      curDm = 1'b0;
      noteBit(b0);
      for (int i = 1; i < 8; i++) sendBit(tail[i]);
      sendEop();
      check(capN == 2, "R7 dribble did not end packet", capN, 2);
      check(capData[1] == {tail[7:1], b0}, "R7 dribble decoded as K",
            int'(capData[1]), int'({tail[7:1], b0}));
      check(doneSeen == 1 && doneCount == 2, "R7 done count", doneCount, 2);
    end

    // R9 lone K then J: no lock, no output
    clearCap();
    sendIdle(4);
    curDm = 1'b0; driveLevel();
    sendIdle(6);
    check(capN == 0 && doneSeen == 0, "R9 no lock on K J", capN + doneSeen, 0);

    // R8 overflow with BUF+1 bytes
    clearCap();
    sendIdle(4);
    sendSync();
    for (int b = 0; b < BUF + 1; b++) sendByte(8'h30 + 8'(b));
    sendEop();
    check(capN == BUF, "R8 bytes before overflow", capN, BUF);
    check(overflow, "R8 overflow raised", int'(overflow), 1);
    check(doneSeen == 0, "R8 no done on overflow", doneSeen, 0);

    // R8 overflow cleared on next lock
    clearCap();
    sendIdle(4);
    sendSync();
    sendByte(8'hE7);
    sendEop();
    check(!overflow, "R8 overflow cleared", int'(overflow), 0);
    check(capN == 1 && capData[0] == 8'hE7, "R2 relock after overflow", int'(capData[0]), 'hE7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule